// File: doc/BRIEF.md
# Ethernet PHY LED Behaviour Controller

This block decides, for each LED of a tri-speed Ethernet PHY, whether that LED is lit in the current clock cycle. Every LED has two configuration bytes. Together they pick the PHY condition that makes the LED steady-on, the condition that makes it blink fast, the condition that makes it blink slowly, and the activity events that make it pulse. The live PHY status comes in on plain inputs: link state and speed, power-down, energy-efficient mode, auto-negotiation, analog self-test, cable diagnostics, and single-cycle transmit, receive and collision strobes.

A shared global rate register sets the two blink rates used by all LEDs. Both rates come from one phase counter, which advances once per step of 1/32 s. A step is `TICKS_PER_STEP` pulses of the slow tick input. An activity event is stretched into one visible flash followed by a guaranteed dark gap, so that bursts of traffic stay readable. Software programs the block through a byte-wide write port and reads it back through a combinational read port.

Top module: `phyled_ctrl`

## Requirements
- R1: After reset the registers read as follows. The rate register at address 0 reads 0xC5. The LED high bytes at addresses 1, 3, 5 and 7 read 0x70, 0x20, 0x40 and 0x40. The LED low bytes at addresses 2, 4, 6 and 8 read 0x03, 0x00, 0x00 and 0x20.
- R2: The register map is as follows. Address 0 is the rate register: fast-rate code in bits 7:6, slow-rate code in bits 5:4, bit 3 reserved, bits 2:0 stored. Address 2n+1 is the high byte of LED n: steady selector in bits 7:4, fast selector in bits 3:0. Address 2n+2 is the low byte of LED n: slow selector in bits 7:4, pulse mask in bits 3:0 with bit 3 reserved. Reserved bits ignore writes and read as 0. Unmapped addresses read 0.
- R3: Selector codes 1 to 7 are a speed mask: bit 0 is 10 Mbit/s, bit 1 is 100 Mbit/s and bit 2 is 1000 Mbit/s. A code is true when the link is up and the bit for the current speed is set. The speed input encodes 0 as 10, 1 as 100, 2 as 1000 and 3 as no speed. Code 0 is never true.
- R4: Selector codes 8, 9, 10, 11 and 12 are true while, respectively, power-down, energy-efficient mode, auto-negotiation, self-test and cable diagnostics are active. Codes 13 to 15 are never true.
- R5: A rate code k of 0, 1, 2 or 3 gives 2, 4, 8 or 16 Hz. A blinking LED therefore toggles every 2^(3-k) steps, and a step is TICKS_PER_STEP tick pulses. With the tick input held low the blink waveform does not advance.
- R6: Priority is fixed: active pulse first, then fast blink, then slow blink, then steady-on. With none of them active the LED is off.
- R7: An activity pulse is started only by an event whose bit is set in the LED's pulse mask: bit 0 is transmit, bit 1 is receive, bit 2 is collision.
- R8: A pulse lights the LED for at least H steps and then darkens it for at least H steps, where H is half the slow blink period (2^(3-slow code) steps). Each phase is at most H+1 steps. Events during either phase are ignored.
- R9: The LED outputs are registered. A status change becomes visible at the first rising clock edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Slow time-base pulse feeding the blink divider |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | 8 | Register read data, combinational |
| link_up_i | input | 1 | Link is up |
| speed_i | input | 2 | Link speed: 0 = 10, 1 = 100, 2 = 1000, 3 = none |
| pdown_i | input | 1 | PHY powered down |
| eee_i | input | 1 | Energy-efficient mode active |
| aneg_i | input | 1 | Auto-negotiation running |
| selftest_i | input | 1 | Analog self-test running |
| cdiag_i | input | 1 | Cable diagnostics running |
| tx_act_i | input | 1 | Transmit activity strobe |
| rx_act_i | input | 1 | Receive activity strobe |
| col_i | input | 1 | Collision strobe |
| led_o | output | NUM_LEDS | LED levels, 1 = lit |

## Verification
The selector decode is swept over every speed-mask code against every speed and link state, so a swapped speed bit or a missing link qualifier shows up. Each status code is then driven with exactly one status input active, which separates a code mapped to the wrong condition from one that is ignored. The blink rates are measured by counting toggles in a fixed window for each rate code, and the same count tells the priority cases apart: steady plus slow, slow plus fast, and pulse over steady. Held activity shows the stretched flash and its dark gap, and their minimum lengths separate a stretcher that retriggers from one that does not.

// File: rtl/phyled_pkg.sv
package phyled_pkg;

  typedef struct packed {
    logic       link;
    logic [1:0] speed;
    logic       pdown;
    logic       eee;
    logic       aneg;
    logic       selftest;
    logic       cdiag;
  } phy_stat_t;

  typedef struct packed {
    logic [3:0] steady;
    logic [3:0] fast;
    logic [3:0] slow;
    logic [2:0] pmask;
  } led_cfg_t;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_ON   = 2'd1,
    PS_OFF  = 2'd2
  } pulse_st_e;

  localparam logic [7:0] RATE_RST   = 8'hC5;
  localparam logic [7:0] RATE_WMASK = 8'hF7;
  localparam logic [7:0] LOW_WMASK  = 8'hF7;

  function automatic logic [7:0] hi_rst(input int idx);
    case (idx)
      0:       return 8'h70;
      1:       return 8'h20;
      2, 3:    return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] lo_rst(input int idx);
    case (idx)
      0:       return 8'h03;
      3:       return 8'h20;
      default: return 8'h00;
    endcase
  endfunction

  // Codes 1..7 form a speed mask, 8..12 map to status flags, others are false.
  function automatic logic cond_hit(input logic [3:0] code, input phy_stat_t st);
    logic hit;
    hit = 1'b0;
    if (!code[3]) begin
      if (st.link && (st.speed != 2'd3)) hit = code[st.speed];
    end else begin
      case (code[2:0])
        3'd0:    hit = st.pdown;
        3'd1:    hit = st.eee;
        3'd2:    hit = st.aneg;
        3'd3:    hit = st.selftest;
        3'd4:    hit = st.cdiag;
        default: hit = 1'b0;
      endcase
    end
    return hit;
  endfunction

endpackage

// File: rtl/phyled_regs.sv
module phyled_regs
  import phyled_pkg::*;
#(
  parameter int NUM_LEDS = 4,
  parameter int ADDR_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [7:0]                wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [7:0]                rd_data,
  output logic [1:0]                fast_rate,
  output logic [1:0]                slow_rate,
  output led_cfg_t [NUM_LEDS-1:0]   cfg
);

  logic [7:0]                rate_q, rate_d;
  logic [NUM_LEDS-1:0][7:0]  hi_q, hi_d;
  logic [NUM_LEDS-1:0][7:0]  lo_q, lo_d;

  // next-state
  always_comb begin
    rate_d = rate_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    if (wr_en) begin
      if (wr_addr == '0) rate_d = wr_data & RATE_WMASK;
      for (int i = 0; i < NUM_LEDS; i++) begin
        if (wr_addr == ADDR_W'(2*i+1)) hi_d[i] = wr_data;
        if (wr_addr == ADDR_W'(2*i+2)) lo_d[i] = wr_data & LOW_WMASK;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= RATE_RST;
      for (int i = 0; i < NUM_LEDS; i++) begin
        hi_q[i] <= hi_rst(i);
        lo_q[i] <= lo_rst(i);
      end
    end else begin
      rate_q <= rate_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
    end
  end

  // read mux
  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == '0) rd_data = rate_q;
    for (int i = 0; i < NUM_LEDS; i++) begin
      if (rd_addr == ADDR_W'(2*i+1)) rd_data = hi_q[i];
      if (rd_addr == ADDR_W'(2*i+2)) rd_data = lo_q[i];
    end
  end

  assign fast_rate = rate_q[7:6];
  assign slow_rate = rate_q[5:4];

  always_comb begin
    for (int i = 0; i < NUM_LEDS; i++) begin
      cfg[i].steady = hi_q[i][7:4];
      cfg[i].fast   = hi_q[i][3:0];
      cfg[i].slow   = lo_q[i][7:4];
      cfg[i].pmask  = lo_q[i][2:0];
    end
  end

endmodule

// File: rtl/phyled_blink.sv
module phyled_blink #(
  parameter int TICKS_PER_STEP = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic [1:0] fast_rate,
  input  logic [1:0] slow_rate,
  output logic       step_o,
  output logic       fast_wave,
  output logic       slow_wave
);

  localparam int CNT_W = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_PER_STEP - 1);

  logic [CNT_W-1:0] tcnt_q, tcnt_d;
  logic             step_q, step_d;
  logic [3:0]       phase_q, phase_d;
  logic             tcnt_en, phase_en;

  assign tcnt_en  = tick_i;
  assign phase_en = step_q;

  // next-state
  always_comb begin
    tcnt_d = tcnt_q;
    step_d = 1'b0;
    if (tcnt_en) begin
      if (tcnt_q == CNT_LAST) begin
        tcnt_d = '0;
        step_d = 1'b1;
      end else begin
        tcnt_d = tcnt_q + 1'b1;
      end
    end
    phase_d = phase_en ? phase_q + 4'd1 : phase_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q  <= '0;
      step_q  <= 1'b0;
      phase_q <= 4'd0;
    end else begin
      tcnt_q  <= tcnt_d;
      step_q  <= step_d;
      phase_q <= phase_d;
    end
  end

  logic [1:0] f_idx, s_idx;
  assign f_idx     = 2'd3 - fast_rate;
  assign s_idx     = 2'd3 - slow_rate;
  assign fast_wave = phase_q[f_idx];
  assign slow_wave = phase_q[s_idx];
  assign step_o    = step_q;

  // R5: the blink phase only moves in a cycle that follows a step strobe
  assert_phase_on_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != $past(phase_q)) |-> $past(step_q));

  // R5: no tick, no step
  assert_step_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> !step_q);

endmodule

// File: rtl/phyled_pulse.sv
module phyled_pulse
  import phyled_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_i,
  input  logic       step_i,
  input  logic [3:0] half_steps,
  output logic       active_o,
  output logic       level_o
);

  pulse_st_e  st_q, st_d;
  logic [3:0] cnt_q, cnt_d;

  // next-state
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      PS_IDLE: begin
        if (evt_i) begin
          st_d  = PS_ON;
          cnt_d = 4'd0;
        end
      end
      PS_ON, PS_OFF: begin
        if (step_i) begin
          if (cnt_q == half_steps) begin
            st_d  = (st_q == PS_ON) ? PS_OFF : PS_IDLE;
            cnt_d = 4'd0;
          end else begin
            cnt_d = cnt_q + 4'd1;
          end
        end
      end
      default: st_d = PS_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_IDLE;
      cnt_q <= 4'd0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign active_o = (st_q != PS_IDLE);
  assign level_o  = (st_q == PS_ON);

  // R8: the dark gap is never cut short by a new event
  assert_off_no_retrigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_OFF) |=> (st_q != PS_ON));

  // R8: a flash is always followed by a dark gap
  assert_on_then_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_ON) |=> (st_q != PS_IDLE));

  // R8: phases only end on a step strobe
  assert_hold_between_steps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q != PS_IDLE) && !step_i) |=> $stable(st_q));

endmodule

// File: rtl/phyled_ctrl.sv
module phyled_ctrl
  import phyled_pkg::*;
#(
  parameter int NUM_LEDS       = 4,
  parameter int TICKS_PER_STEP = 32,
  parameter int ADDR_W         = $clog2(2*NUM_LEDS+1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [7:0]          wr_data_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [7:0]          rd_data_o,
  input  logic                link_up_i,
  input  logic [1:0]          speed_i,
  input  logic                pdown_i,
  input  logic                eee_i,
  input  logic                aneg_i,
  input  logic                selftest_i,
  input  logic                cdiag_i,
  input  logic                tx_act_i,
  input  logic                rx_act_i,
  input  logic                col_i,
  output logic [NUM_LEDS-1:0] led_o
);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  led_cfg_t [NUM_LEDS-1:0] cfg;
  logic [1:0] fast_rate, slow_rate;
  logic       step, fast_wave, slow_wave;
  logic [3:0] half_steps;

  phyled_regs #(.NUM_LEDS(NUM_LEDS), .ADDR_W(ADDR_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en_i),
    .wr_addr   (wr_addr_i),
    .wr_data   (wr_data_i),
    .rd_addr   (rd_addr_i),
    .rd_data   (rd_data_o),
    .fast_rate (fast_rate),
    .slow_rate (slow_rate),
    .cfg       (cfg)
  );

  phyled_blink #(.TICKS_PER_STEP(TICKS_PER_STEP)) blink_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick_i    (tick_i),
    .fast_rate (fast_rate),
    .slow_rate (slow_rate),
    .step_o    (step),
    .fast_wave (fast_wave),
    .slow_wave (slow_wave)
  );

  assign half_steps = 4'd1 << (2'd3 - slow_rate);

  phy_stat_t stat;
  assign stat = '{link: link_up_i, speed: speed_i, pdown: pdown_i, eee: eee_i,
                  aneg: aneg_i, selftest: selftest_i, cdiag: cdiag_i};

  logic [2:0]          act_vec;
  assign act_vec = {col_i, rx_act_i, tx_act_i};

  logic [NUM_LEDS-1:0] steady_hit, fast_hit, slow_hit, evt, p_act, p_lvl;
  logic [NUM_LEDS-1:0] led_d, led_q;

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_lane
    assign steady_hit[i] = cond_hit(cfg[i].steady, stat);
    assign fast_hit[i]   = cond_hit(cfg[i].fast, stat);
    assign slow_hit[i]   = cond_hit(cfg[i].slow, stat);
    assign evt[i]        = |(cfg[i].pmask & act_vec);

    phyled_pulse pulse_i (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .evt_i      (evt[i]),
      .step_i     (step),
      .half_steps (half_steps),
      .active_o   (p_act[i]),
      .level_o    (p_lvl[i])
    );

    // R6: nothing active means a dark LED in the next cycle
    assert_dark_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!p_act[i] && !fast_hit[i] && !slow_hit[i] && !steady_hit[i]) |=> !led_o[i]);

    // R6: an active pulse decides the LED over every other term
    assert_pulse_first_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      p_act[i] |=> (led_o[i] == $past(p_lvl[i])));
  end

  // priority select
  always_comb begin
    for (int i = 0; i < NUM_LEDS; i++) begin
      if (p_act[i])         led_d[i] = p_lvl[i];
      else if (fast_hit[i]) led_d[i] = fast_wave;
      else if (slow_hit[i]) led_d[i] = slow_wave;
      else                  led_d[i] = steady_hit[i];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) led_q <= '0;
    else             led_q <= led_d;
  end

  assign led_o = led_q;

endmodule

// File: tb/phyled_ctrl_tb.sv
module phyled_ctrl_tb_top;

  localparam int NL  = 4;
  localparam int TPS = 2;
  localparam int AW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b1;
  logic wr_en_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic link_up_i = 0, pdown_i = 0, eee_i = 0, aneg_i = 0, selftest_i = 0, cdiag_i = 0;
  logic tx_act_i = 0, rx_act_i = 0, col_i = 0;
  logic [1:0] speed_i = 2'd0;
  logic [NL-1:0] led_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  phyled_ctrl #(.NUM_LEDS(NL), .TICKS_PER_STEP(TPS), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .link_up_i(link_up_i), .speed_i(speed_i), .pdown_i(pdown_i), .eee_i(eee_i),
    .aneg_i(aneg_i), .selftest_i(selftest_i), .cdiag_i(cdiag_i),
    .tx_act_i(tx_act_i), .rx_act_i(rx_act_i), .col_i(col_i), .led_o(led_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int addr, input logic [7:0] data);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = AW'(addr); wr_data_i = data;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [7:0] data);
    rd_addr_i = AW'(addr);
    #0.5;
    data = rd_data_o;
  endtask

  task automatic set_stat(input logic lk, input logic [1:0] sp, input logic [4:0] flags);
    link_up_i = lk; speed_i = sp;
    {pdown_i, eee_i, aneg_i, selftest_i, cdiag_i} = flags;
  endtask

  task automatic count_toggles(input int n, output int tg);
    logic prev;
    tg = 0;
    prev = led_o[1];
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (led_o[1] != prev) tg++;
      prev = led_o[1];
    end
  endtask

  // R1
  task automatic t_reset();
    logic [7:0] v;
    logic [7:0] hi_e [4] = '{8'h70, 8'h20, 8'h40, 8'h40};
    logic [7:0] lo_e [4] = '{8'h03, 8'h00, 8'h00, 8'h20};
    rd(0, v); chk("R1 rate reset", int'(v), 'hC5);
    for (int i = 0; i < 4; i++) begin
      rd(2*i+1, v); chk("R1 high reset", int'(v), int'(hi_e[i]));
      rd(2*i+2, v); chk("R1 low reset", int'(v), int'(lo_e[i]));
    end
    chk("R1 leds dark", int'(led_o), 0);
  endtask

  // R2
  task automatic t_regs();
    logic [7:0] v;
    wr(0, 8'hFF); rd(0, v); chk("R2 rate reserved bit", int'(v), 'hF7);
    wr(4, 8'hFF); rd(4, v); chk("R2 low reserved bit", int'(v), 'hF7);
    wr(5, 8'hA5); rd(5, v); chk("R2 high byte write", int'(v), 'hA5);
    rd(3, v); chk("R2 neighbour untouched", int'(v), 'h20);
    wr(12, 8'h5A); rd(12, v); chk("R2 unmapped reads zero", int'(v), 0);
    for (int a = 1; a <= 8; a++) wr(a, 8'h00);
  endtask

  // R3
  task automatic t_speed();
    int e;
    wr(4, 8'h00);
    for (int code = 0; code < 8; code++) begin
      wr(3, 8'(code << 4));
      for (int lk = 0; lk < 2; lk++)
        for (int sp = 0; sp < 4; sp++) begin
          set_stat(lk[0], sp[1:0], 5'b0);
          wait_cyc(2);
          e = (lk == 1 && sp != 3) ? ((code >> sp) & 1) : 0;
          chk("R3 speed mask decode", int'(led_o[1]), e);
        end
    end
  endtask

  // R4
  task automatic t_flags();
    for (int code = 8; code < 13; code++) begin
      wr(3, 8'(code << 4));
      for (int j = 0; j < 5; j++) begin
        set_stat(1'b0, 2'd3, 5'b10000 >> j);
        wait_cyc(2);
        chk("R4 status code decode", int'(led_o[1]), (code - 8 == j) ? 1 : 0);
      end
    end
    set_stat(1'b1, 2'd2, 5'b11111);
    for (int code = 13; code < 17; code++) begin
      wr(3, 8'((code & 15) << 4));
      wait_cyc(2);
      chk("R4 no-condition codes", int'(led_o[1]), 0);
    end
  endtask

  // R5
  task automatic t_rates();
    int tg;
    set_stat(1'b1, 2'd1, 5'b0);
    wr(3, 8'h07); wr(4, 8'h00);
    for (int k = 0; k < 4; k++) begin
      wr(0, 8'(k << 6));
      wait_cyc(2);
      count_toggles(128, tg);
      chk("R5 fast rate toggles", tg, 8 << k);
    end
    wr(3, 8'h00); wr(4, 8'h70);
    for (int k = 0; k < 4; k++) begin
      wr(0, 8'(k << 4));
      wait_cyc(2);
      count_toggles(128, tg);
      chk("R5 slow rate toggles", tg, 8 << k);
    end
    tick_i = 1'b0;
    wait_cyc(3);
    count_toggles(40, tg);
    chk("R5 frozen without tick", tg, 0);
    tick_i = 1'b1;
  endtask

  // R6
  task automatic t_prio();
    int tg;
    set_stat(1'b1, 2'd2, 5'b0);
    wr(0, 8'hC0);
    wr(3, 8'h70); wr(4, 8'h00); wait_cyc(2);
    count_toggles(64, tg);
    chk("R6 steady only no toggles", tg, 0);
    chk("R6 steady only lit", int'(led_o[1]), 1);
    wr(4, 8'h70); wait_cyc(2);
    count_toggles(128, tg);
    chk("R6 slow over steady", tg, 8);
    wr(3, 8'h77); wait_cyc(2);
    count_toggles(128, tg);
    chk("R6 fast over slow", tg, 64);
    wr(3, 8'h00); wr(4, 8'h00); wait_cyc(2);
    count_toggles(32, tg);
    chk("R6 nothing active no toggles", tg, 0);
    chk("R6 nothing active dark", int'(led_o[1]), 0);
  endtask

  task automatic fire(input int b);
    @(negedge clk);
    {col_i, rx_act_i, tx_act_i} = 3'(1 << b);
    @(negedge clk);
    {col_i, rx_act_i, tx_act_i} = 3'b000;
  endtask

  // R7
  task automatic t_mask();
    int seen;
    set_stat(1'b0, 2'd3, 5'b0);
    wr(0, 8'h30);
    wr(3, 8'h00);
    for (int b = 0; b < 3; b++) begin
      wr(4, 8'(1 << b));
      fire(b);
      seen = 0;
      for (int k = 0; k < 4; k++) begin @(negedge clk); if (led_o[1]) seen = 1; end
      chk("R7 enabled event pulses", seen, 1);
      wait_cyc(30);
      wr(4, 8'(7 & ~(1 << b)) | 8'h08);
      fire(b);
      seen = 0;
      for (int k = 0; k < 8; k++) begin @(negedge clk); if (led_o[1]) seen = 1; end
      chk("R7 masked event ignored", seen, 0);
    end
  endtask

  task automatic runs(input int n, output int min_on, output int max_on,
                      output int min_off, output int n_on, output int n_off);
    logic prev;
    int run;
    bit started;
    min_on = 999; max_on = 0; min_off = 999; n_on = 0; n_off = 0;
    started = 0; run = 0;
    prev = led_o[1];
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (led_o[1] == prev) run++;
      else begin
        if (started) begin
          if (prev) begin n_on++; if (run < min_on) min_on = run; if (run > max_on) max_on = run; end
          else begin n_off++; if (run < min_off) min_off = run; end
        end
        started = 1; run = 1;
      end
      prev = led_o[1];
    end
  endtask

  // R8
  task automatic t_stretch();
    int mn_on, mx_on, mn_off, c_on, c_off;
    set_stat(1'b1, 2'd0, 5'b0);
    wr(0, 8'h00);
    wr(3, 8'h00); wr(4, 8'h01);
    wait_cyc(2);
    tx_act_i = 1'b1;
    runs(160, mn_on, mx_on, mn_off, c_on, c_off);
    tx_act_i = 1'b0;
    chk("R8 at least two flashes", int'(c_on >= 2), 1);
    chk("R8 flash long enough", int'(mn_on >= 16), 1);
    chk("R8 flash not too long", int'(mx_on <= 19), 1);
    chk("R8 gap long enough", int'(mn_off >= 16), 1);
    wait_cyc(50);
    wr(3, 8'h70);
    wait_cyc(2);
    tx_act_i = 1'b1;
    runs(160, mn_on, mx_on, mn_off, c_on, c_off);
    tx_act_i = 1'b0;
    chk("R6 pulse gap darkens steady LED", int'(c_off >= 2), 1);
    chk("R8 gap over steady long enough", int'(mn_off >= 16), 1);
    wait_cyc(50);
  endtask

  // R9
  task automatic t_latency();
    wr(4, 8'h00); wr(3, 8'h70);
    set_stat(1'b0, 2'd0, 5'b0);
    wait_cyc(3);
    link_up_i = 1'b1;
    #1;
    chk("R9 no change before edge", int'(led_o[1]), 0);
    @(negedge clk);
    chk("R9 change after one edge", int'(led_o[1]), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_regs();
    t_speed();
    t_flags();
    t_rates();
    t_prio();
    t_mask();
    t_stretch();
    t_latency();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule